// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO and Status Logic

This block sits between a host register port and an SPI shift engine and holds the frame buffering plus the flags that software and DMA watch. The host pushes 16-bit frames into a four-entry transmit FIFO. The shift engine takes them one at a time through a valid/ready load handshake. At the end of every transfer the engine presents the received frame on a capture strobe, and it is stored in a four-entry receive FIFO that the host drains with pop reads.

The status side exposes several items. The fill flag requests more transmit data. The done flag is set by each finished transfer. The underflow flag records a transfer that an external master started in slave mode while nothing was queued. The overflow flag records a capture that found the receive FIFO full. The block also shows both entry counters and the index of the receive slot that the next pop returns. The fill flag is routed to either a DMA request or an interrupt request. Two flush inputs empty the transmit and receive FIFOs.

Back-pressure rules: `push_ready` is high while the transmit FIFO has room. A push presented while `push_ready` is low is discarded without any error indication. On the load side an entry leaves the transmit FIFO in each cycle where `ld_valid` and `ld_ready` are both high. The capture side has no ready. A capture into a full receive FIFO is discarded and raises the overflow flag.

Top module: `spi_fifo_status`

## Requirements
- R1: A push (`push_valid`) is accepted only while `tx_count` is below 4. A push into a full transmit FIFO leaves `tx_count` and the queued frames unchanged and raises no flag.
- R2: `fill_flag` is 1 after reset. A `w1c_fill` pulse clears it, and so does a push with `push_dma`=1 that leaves the FIFO full. Otherwise it is set in every cycle that ends with the transmit FIFO not full, and it holds its value while the FIFO stays full.
- R3: `fill_dma_req` equals `fill_flag` when `fill_sel_dma`=1, and `fill_irq_req` equals `fill_flag` when `fill_sel_dma`=0. The other request is 0.
- R4: `ld_valid` is high while `tx_count` is nonzero, and `ld_data` shows the oldest queued frame. Each cycle with `ld_valid` and `ld_ready` high removes that frame and decrements `tx_count` by one, in first-in first-out order.
- R5: `xfer_done` sets `done_flag` on the next cycle. `w1c_done` clears it, and a set in the same cycle wins.
- R6: `xfer_start` with `slave_mode`=1 while `tx_count` is 0 sets `udf_flag`. A start with frames queued, or with `slave_mode`=0, leaves it unchanged. `w1c_udf` clears it.
- R7: `clr_tx` empties the transmit FIFO by the next cycle. `clr_rx` empties the receive FIFO and returns `pop_ptr` to 0. A flush wins over a push, load, capture or pop in the same cycle.
- R8: A `cap_valid` strobe while `rx_count` is below 4 stores `cap_data` and increments `rx_count`.
- R9: `pop_req` with `rx_count` nonzero places the oldest received frame on `pop_data` in the next cycle and decrements `rx_count`.
- R10: `pop_ptr` is 0 after reset and gives the slot index (0 to 3) that the next pop returns. It advances by one modulo 4 on every successful pop.
- R11: `pop_req` with an empty receive FIFO leaves `pop_data`, `rx_count` and `pop_ptr` unchanged.
- R12: A `cap_valid` strobe while `rx_count` is 4 discards the frame and sets `ovf_flag`. `w1c_ovf` clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Host push strobe |
| push_data | input | 16 | Frame to queue for transmit |
| push_dma | input | 1 | Push is issued by the DMA side |
| push_ready | output | 1 | Transmit FIFO has room |
| ld_valid | output | 1 | A transmit frame is available to the shift engine |
| ld_ready | input | 1 | Shift engine takes the frame this cycle |
| ld_data | output | 16 | Oldest transmit frame |
| cap_valid | input | 1 | End-of-transfer capture strobe |
| cap_data | input | 16 | Received frame from the shift register |
| xfer_done | input | 1 | A transfer has completed |
| xfer_start | input | 1 | An external master started a transfer |
| slave_mode | input | 1 | Block operates as a slave |
| pop_req | input | 1 | Host pop read strobe |
| pop_data | output | 16 | Frame returned by the last successful pop |
| clr_tx | input | 1 | Flush transmit FIFO |
| clr_rx | input | 1 | Flush receive FIFO |
| fill_sel_dma | input | 1 | Route fill flag to DMA (1) or interrupt (0) |
| w1c_fill | input | 1 | Clear fill flag |
| w1c_done | input | 1 | Clear done flag |
| w1c_udf | input | 1 | Clear underflow flag |
| w1c_ovf | input | 1 | Clear overflow flag |
| fill_flag | output | 1 | Transmit fill flag |
| done_flag | output | 1 | Transfer-complete flag |
| udf_flag | output | 1 | Transmit underflow flag |
| ovf_flag | output | 1 | Receive overflow flag |
| fill_dma_req | output | 1 | DMA request from the fill flag |
| fill_irq_req | output | 1 | Interrupt request from the fill flag |
| tx_count | output | 3 | Transmit entries held |
| rx_count | output | 3 | Receive entries held |
| pop_ptr | output | 2 | Slot returned by the next pop |

## Verification
The assertions treat every strobe as a per-cycle level. They assume `push_dma` matters only together with `push_valid`, and that a flush may coincide with any other operation, with the flush winning. The stimulus drives every input on the falling edge and holds it for exactly one cycle, so each strobe is seen by a single rising edge. A load is requested only while `ld_valid` is high, except where a test drives it on purpose. Receive-side pops are issued both with and without queued frames, so the hold-on-empty properties are exercised.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef struct packed {
    logic fill;
    logic done;
    logic udf;
    logic ovf;
  } sfs_flags_t;

  localparam sfs_flags_t FLAGS_RESET = '{fill: 1'b1, done: 1'b0, udf: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          empty,
  output logic          wr_ok,
  output logic          rd_ok
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [DEPTH-1:0] slot_we;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign wr_ok = wr_en && !full && !flush;
  assign rd_ok = rd_en && !empty && !flush;
  assign head  = mem[rd_ptr];

  always_comb begin
    if (flush) begin
      count_nxt = '0;
    end else begin
      unique case ({wr_ok, rd_ok})
        2'b10:   count_nxt = count + CW'(1);
        2'b01:   count_nxt = count - CW'(1);
        default: count_nxt = count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_we[i] = wr_ok && (wr_ptr == PW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> $stable(count)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && rd_ptr == '0)); // R7
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en && !flush) |=> ($stable(rd_ptr) && count == '0)); // R11
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr_en && !flush) |=> (count == $past(count) - CW'(1))); // R4

endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
  import sfs_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_count_nxt,
  input  logic          dma_push,
  input  logic          slave_mode,
  input  logic          xfer_start,
  input  logic          xfer_done,
  input  logic          ovf_evt,
  input  sfs_flags_t    w1c,
  output sfs_flags_t    flags
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic tx_full_nxt;
  logic fill_clr;
  logic udf_evt;

  assign tx_full_nxt = (tx_count_nxt == FULL_CNT);
  assign fill_clr    = w1c.fill || (dma_push && tx_full_nxt);
  assign udf_evt     = slave_mode && xfer_start && (tx_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= FLAGS_RESET;
    end else begin
      if (fill_clr)          flags.fill <= 1'b0;
      else if (!tx_full_nxt) flags.fill <= 1'b1;

      if (xfer_done)         flags.done <= 1'b1;
      else if (w1c.done)     flags.done <= 1'b0;

      if (udf_evt)           flags.udf  <= 1'b1;
      else if (w1c.udf)      flags.udf  <= 1'b0;

      if (ovf_evt)           flags.ovf  <= 1'b1;
      else if (w1c.ovf)      flags.ovf  <= 1'b0;
    end
  end

  AST_FILL_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.fill && tx_count != FULL_CNT) |-> $past(w1c.fill)); // R2
  AST_FILL_DMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_push && tx_full_nxt) |=> !flags.fill); // R2
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> flags.done); // R5
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && xfer_start && tx_count == '0) |=> flags.udf); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags.ovf); // R12

endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import sfs_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int RX_PW   = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [FRAME_W-1:0] push_data,
  input  logic               push_dma,
  output logic               push_ready,
  output logic               ld_valid,
  input  logic               ld_ready,
  output logic [FRAME_W-1:0] ld_data,
  input  logic               cap_valid,
  input  logic [FRAME_W-1:0] cap_data,
  input  logic               xfer_done,
  input  logic               xfer_start,
  input  logic               slave_mode,
  input  logic               pop_req,
  output logic [FRAME_W-1:0] pop_data,
  input  logic               clr_tx,
  input  logic               clr_rx,
  input  logic               fill_sel_dma,
  input  logic               w1c_fill,
  input  logic               w1c_done,
  input  logic               w1c_udf,
  input  logic               w1c_ovf,
  output logic               fill_flag,
  output logic               done_flag,
  output logic               udf_flag,
  output logic               ovf_flag,
  output logic               fill_dma_req,
  output logic               fill_irq_req,
  output logic [TX_CW-1:0]   tx_count,
  output logic [RX_CW-1:0]   rx_count,
  output logic [RX_PW-1:0]   pop_ptr
);

  localparam int TX_PW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;

  logic [TX_CW-1:0]   tx_count_nxt;
  logic [TX_PW-1:0]   tx_rd_ptr;
  logic               tx_full, tx_empty, tx_wr_ok, tx_rd_ok;
  logic [FRAME_W-1:0] rx_head;
  logic [RX_CW-1:0]   rx_count_nxt;
  logic               rx_full, rx_empty, rx_wr_ok, rx_rd_ok;
  logic               ovf_evt;
  sfs_flags_t         w1c, flags;

  sfs_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (clr_tx),
    .wr_en     (push_valid),
    .wr_data   (push_data),
    .rd_en     (ld_ready),
    .head      (ld_data),
    .count     (tx_count),
    .count_nxt (tx_count_nxt),
    .rd_ptr    (tx_rd_ptr),
    .full      (tx_full),
    .empty     (tx_empty),
    .wr_ok     (tx_wr_ok),
    .rd_ok     (tx_rd_ok)
  );

  sfs_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (clr_rx),
    .wr_en     (cap_valid),
    .wr_data   (cap_data),
    .rd_en     (pop_req),
    .head      (rx_head),
    .count     (rx_count),
    .count_nxt (rx_count_nxt),
    .rd_ptr    (pop_ptr),
    .full      (rx_full),
    .empty     (rx_empty),
    .wr_ok     (rx_wr_ok),
    .rd_ok     (rx_rd_ok)
  );

  assign push_ready = !tx_full;
  assign ld_valid   = !tx_empty;
  assign ovf_evt    = cap_valid && rx_full && !clr_rx;

  assign w1c = '{fill: w1c_fill, done: w1c_done, udf: w1c_udf, ovf: w1c_ovf};

  sfs_flags #(.DEPTH(TX_DEPTH)) i_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_count     (tx_count),
    .tx_count_nxt (tx_count_nxt),
    .dma_push     (push_valid && push_dma),
    .slave_mode   (slave_mode),
    .xfer_start   (xfer_start),
    .xfer_done    (xfer_done),
    .ovf_evt      (ovf_evt),
    .w1c          (w1c),
    .flags        (flags)
  );

  assign fill_flag    = flags.fill;
  assign done_flag    = flags.done;
  assign udf_flag     = flags.udf;
  assign ovf_flag     = flags.ovf;
  assign fill_dma_req = flags.fill && fill_sel_dma;
  assign fill_irq_req = flags.fill && !fill_sel_dma;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pop_data <= '0;
    else if (rx_rd_ok) pop_data <= rx_head;
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_dma_req, fill_irq_req})); // R3
  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_flag |-> (fill_dma_req || fill_irq_req)); // R3
  AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && rx_count == '0 && !clr_rx) |=> $stable(pop_data)); // R11
  AST_LOAD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && !push_valid) |=> !ld_valid); // R4

endmodule

// File: tb/test_spi_fifo_status.sv
module test_spi_fifo_status;

  localparam logic [1:0] OP_PUSH = 2'd0;
  localparam logic [1:0] OP_LOAD = 2'd1;
  localparam logic [1:0] OP_CAP  = 2'd2;
  localparam logic [1:0] OP_POP  = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] din;
    logic [2:0]  cnt;
    logic        chk;
    logic [15:0] dout;
    logic [1:0]  ptr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{OP_PUSH, 16'h1111, 3'd1, 1'b1, 16'h1111, 2'd0},
    '{OP_PUSH, 16'h2222, 3'd2, 1'b1, 16'h1111, 2'd0},
    '{OP_PUSH, 16'h3333, 3'd3, 1'b1, 16'h1111, 2'd0},
    '{OP_PUSH, 16'h4444, 3'd4, 1'b1, 16'h1111, 2'd0},
    '{OP_PUSH, 16'h5555, 3'd4, 1'b1, 16'h1111, 2'd0},
    '{OP_LOAD, 16'h0000, 3'd3, 1'b1, 16'h2222, 2'd0},
    '{OP_LOAD, 16'h0000, 3'd2, 1'b1, 16'h3333, 2'd0},
    '{OP_PUSH, 16'h6666, 3'd3, 1'b1, 16'h3333, 2'd0},
    '{OP_LOAD, 16'h0000, 3'd2, 1'b1, 16'h4444, 2'd0},
    '{OP_LOAD, 16'h0000, 3'd1, 1'b1, 16'h6666, 2'd0},
    '{OP_LOAD, 16'h0000, 3'd0, 1'b0, 16'h0000, 2'd0},
    '{OP_CAP,  16'hA001, 3'd1, 1'b1, 16'h0000, 2'd0},
    '{OP_CAP,  16'hA002, 3'd2, 1'b1, 16'h0000, 2'd0},
    '{OP_CAP,  16'hA003, 3'd3, 1'b1, 16'h0000, 2'd0},
    '{OP_POP,  16'h0000, 3'd2, 1'b1, 16'hA001, 2'd1},
    '{OP_CAP,  16'hA004, 3'd3, 1'b1, 16'hA001, 2'd1},
    '{OP_CAP,  16'hA005, 3'd4, 1'b1, 16'hA001, 2'd1},
    '{OP_CAP,  16'hA006, 3'd4, 1'b1, 16'hA001, 2'd1},
    '{OP_POP,  16'h0000, 3'd3, 1'b1, 16'hA002, 2'd2},
    '{OP_POP,  16'h0000, 3'd2, 1'b1, 16'hA003, 2'd3},
    '{OP_POP,  16'h0000, 3'd1, 1'b1, 16'hA004, 2'd0},
    '{OP_POP,  16'h0000, 3'd0, 1'b1, 16'hA005, 2'd1},
    '{OP_POP,  16'h0000, 3'd0, 1'b1, 16'hA005, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, push_dma = 0, ld_ready = 0, cap_valid = 0;
  logic [15:0] push_data = '0, cap_data = '0;
  logic        xfer_done = 0, xfer_start = 0, slave_mode = 0, pop_req = 0;
  logic        clr_tx = 0, clr_rx = 0, fill_sel_dma = 0;
  logic        w1c_fill = 0, w1c_done = 0, w1c_udf = 0, w1c_ovf = 0;
  logic        push_ready, ld_valid;
  logic [15:0] ld_data, pop_data;
  logic        fill_flag, done_flag, udf_flag, ovf_flag, fill_dma_req, fill_irq_req;
  logic [2:0]  tx_count, rx_count;
  logic [1:0]  pop_ptr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fifo_status i_spi_fifo_status (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data), .push_dma(push_dma), .push_ready(push_ready),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .slave_mode(slave_mode),
    .pop_req(pop_req), .pop_data(pop_data),
    .clr_tx(clr_tx), .clr_rx(clr_rx), .fill_sel_dma(fill_sel_dma),
    .w1c_fill(w1c_fill), .w1c_done(w1c_done), .w1c_udf(w1c_udf), .w1c_ovf(w1c_ovf),
    .fill_flag(fill_flag), .done_flag(done_flag), .udf_flag(udf_flag), .ovf_flag(ovf_flag),
    .fill_dma_req(fill_dma_req), .fill_irq_req(fill_irq_req),
    .tx_count(tx_count), .rx_count(rx_count), .pop_ptr(pop_ptr)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_valid = 0; push_dma = 0; ld_ready = 0; cap_valid = 0;
    xfer_done = 0; xfer_start = 0; pop_req = 0; clr_tx = 0; clr_rx = 0;
    w1c_fill = 0; w1c_done = 0; w1c_udf = 0; w1c_ovf = 0;
  endtask

  // Inputs are set right after a falling edge; this waits one full cycle.
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_push(input logic [15:0] d, input logic dma);
    push_valid = 1; push_data = d; push_dma = dma; step();
  endtask

  task automatic do_cap(input logic [15:0] d);
    cap_valid = 1; cap_data = d; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R2 fill set, R10 pointer zero, R4 nothing to load
    check("R2 reset fill", {39'd0, fill_flag}, 40'd1);
    check("R10 reset pop_ptr/counts", {32'd0, tx_count, rx_count, pop_ptr}, 40'd0);
    check("R4 reset ld_valid", {38'd0, ld_valid, push_ready}, 40'd1);
    check("R5 R6 R12 reset flags", {37'd0, done_flag, udf_flag, ovf_flag}, 40'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [15:0] obs;
      logic [2:0]  cnt;
      case (VEC[i].op)
        OP_PUSH: begin push_valid = 1; push_data = VEC[i].din; tag = "R1 push"; end
        OP_LOAD: begin ld_ready = 1; tag = "R4 load"; end
        OP_CAP:  begin cap_valid = 1; cap_data = VEC[i].din;
                       tag = (i == 17) ? "R12 capture full" : "R8 capture"; end
        default: begin pop_req = 1;
                       tag = (i == 22) ? "R11 pop empty" : "R9 pop"; end
      endcase
      step();
      if (VEC[i].op == OP_PUSH || VEC[i].op == OP_LOAD) begin
        obs = ld_data; cnt = tx_count;
        check(tag, {19'd0, cnt, VEC[i].chk ? obs : 16'h0, 2'd0},
                   {19'd0, VEC[i].cnt, VEC[i].chk ? VEC[i].dout : 16'h0, 2'd0});
      end else begin
        obs = pop_data; cnt = rx_count;
        check(tag, {19'd0, cnt, obs, pop_ptr},
                   {19'd0, VEC[i].cnt, VEC[i].dout, VEC[i].ptr});
      end
    end

    // R11: another pop on empty, everything held
    pop_req = 1; step();
    check("R11 empty pop hold", {19'd0, rx_count, pop_data, pop_ptr}, {19'd0, 3'd0, 16'hA005, 2'd1});

    // R12: overflow flag stays until cleared
    check("R12 ovf set", {39'd0, ovf_flag}, 40'd1);
    w1c_ovf = 1; step();
    check("R12 ovf clear", {39'd0, ovf_flag}, 40'd0);

    // R5: done flag
    xfer_done = 1; step();
    check("R5 done set", {39'd0, done_flag}, 40'd1);
    w1c_done = 1; step();
    check("R5 done clear", {39'd0, done_flag}, 40'd0);
    xfer_done = 1; w1c_done = 1; step();
    check("R5 set wins over clear", {39'd0, done_flag}, 40'd1);

    // R6: underflow
    slave_mode = 1; xfer_start = 1; step();
    check("R6 udf slave empty", {39'd0, udf_flag}, 40'd1);
    w1c_udf = 1; step();
    check("R6 udf clear", {39'd0, udf_flag}, 40'd0);
    do_push(16'hC001, 1'b0);
    xfer_start = 1; step();
    check("R6 no udf when queued", {39'd0, udf_flag}, 40'd0);

    // R7: flushes
    do_push(16'hC002, 1'b0);
    do_push(16'hC003, 1'b0);
    check("R7 tx before flush", {37'd0, tx_count}, 40'd3);
    clr_tx = 1; step();
    check("R7 tx flush", {36'd0, tx_count, ld_valid}, 40'd0);
    slave_mode = 0; xfer_start = 1; step();
    check("R6 no udf in master mode", {39'd0, udf_flag}, 40'd0);
    push_valid = 1; push_data = 16'hC004; clr_tx = 1; step();
    check("R7 flush wins over push", {37'd0, tx_count}, 40'd0);
    do_cap(16'hB001);
    do_cap(16'hB002);
    check("R8 rx two captured", {35'd0, rx_count, pop_ptr}, {35'd0, 3'd2, 2'd1});
    clr_rx = 1; pop_req = 1; step();
    check("R7 rx flush", {19'd0, rx_count, pop_data, pop_ptr}, {19'd0, 3'd0, 16'hA005, 2'd0});
    do_cap(16'hB003);
    pop_req = 1; step();
    check("R9 R10 pop after flush", {19'd0, rx_count, pop_data, pop_ptr}, {19'd0, 3'd0, 16'hB003, 2'd1});

    // R2 / R3: fill flag and request routing
    fill_sel_dma = 0; step();
    check("R3 irq route", {37'd0, fill_flag, fill_irq_req, fill_dma_req}, {37'd0, 3'b110});
    do_push(16'hD001, 1'b0);
    do_push(16'hD002, 1'b0);
    do_push(16'hD003, 1'b0);
    check("R2 fill while not full", {39'd0, fill_flag}, 40'd1);
    do_push(16'hD004, 1'b1);
    check("R2 dma push fills -> clear", {36'd0, tx_count, fill_flag}, {36'd0, 3'd4, 1'b0});
    check("R3 no req when clear", {38'd0, fill_irq_req, fill_dma_req}, 40'd0);
    ld_ready = 1; step();
    check("R2 fill set after load", {35'd0, tx_count, fill_flag, ld_data == 16'hD002},
          {35'd0, 3'd3, 1'b1, 1'b1});
    fill_sel_dma = 1; #1;
    check("R3 dma route", {38'd0, fill_dma_req, fill_irq_req}, {38'd0, 2'b10});
    @(negedge clk);
    w1c_fill = 1; step();
    check("R2 w1c clears fill", {39'd0, fill_flag}, 40'd0);
    step();
    check("R2 fill resets when not full", {39'd0, fill_flag}, 40'd1);
    do_push(16'hD005, 1'b0);
    check("R2 cpu fill keeps flag", {35'd0, tx_count, fill_flag, push_ready}, {35'd0, 3'd4, 1'b1, 1'b0});
    do_push(16'hD006, 1'b1);
    check("R1 R2 dma push into full", {35'd0, tx_count, fill_flag, ld_data == 16'hD002},
          {35'd0, 3'd4, 1'b0, 1'b1});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule